// File: doc/BRIEF.md
# Memory Access Permission Checker with Fault Capture

This block sits beside the address translation stage and judges each memory access the processor presents. It checks three things: whether the address is aligned for the access size, whether a user-mode access reaches into the upper half of the address space, and whether a matching translation entry grants the access in the current privilege mode. When a check fails, the block raises an exception strobe in the same cycle, together with an event code, the vector offset and the updated status word. On that clock edge it also records the fault context in its capture registers.

A translation entry carries a 2-bit protection field, a dirty bit and the way that matched. Privileged mode and user mode read that protection field differently. A store to a clean page that is otherwise permitted raises a separate event, so that software can track pages that have been written. The exception strobe also tells the core to copy the program counter and status word into their save registers. Looking up the translation entry, walking the page table and running the pipeline are all done elsewhere.

Top module: `mmu_access_check`

## Requirements
- R1: Encodings are kind 0 fetch, 1 read, 2 write (3 acts as a read) and size 0 byte, 1 word, 2 or 3 longword. An access is misaligned if it is a fetch with address bit 0 set, a word with bit 0 set, or a longword with either of bits 1:0 set. A byte access on its own is never misaligned.
- R2: A user-mode access (priv_i = 0) with address bit 31 set is an address error. The same address in privileged mode does not raise this error.
- R3: Address errors give event code 0x100 for a write and 0x0E0 for a fetch or read.
- R4: The protection field grants these rights. Value 3: read and write in both modes. Value 2: read only in both modes. Value 1: read and write in privileged mode, nothing in user mode. Value 0: read only in privileged mode, nothing in user mode. A fetch needs read rights.
- R5: A protection failure raises an exception only when tlb_hit_i = 1. It gives code 0x0C0 for a write and 0x0A0 for a fetch or read.
- R6: A permitted write that hits an entry whose dirty bit is 0 gives code 0x080.
- R7: At most one event is raised per access. Address errors take priority over protection failures, and protection failures take priority over the clean-page write.
- R8: vec_off_o is 0x100 whenever exc_o is 1, and 0 otherwise. exc_code_o is 0 whenever exc_o is 0.
- R9: sr_o equals sr_i with bits 28, 29 and 30 forced to 1 while exc_o is 1. Otherwise sr_o equals sr_i.
- R10: On the clock edge where exc_o is 1, fault_addr_o takes the full address. For events with code 0x080, 0x0A0 or 0x0C0, fault_vpn_o also takes address bits 31:10, fault_asid_o takes asid_i and fault_way_o takes tlb_way_i. Address errors leave these three fields unchanged, and every capture register holds its value while exc_o is 0.
- R11: Reset clears all capture registers to 0. While valid_i is 0, no exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An access is presented this cycle |
| vaddr_i | input | 32 | Virtual address of the access |
| kind_i | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| size_i | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| priv_i | input | 1 | 1 for privileged mode, 0 for user mode |
| asid_i | input | 8 | Current address space identifier |
| sr_i | input | 32 | Current status word |
| tlb_hit_i | input | 1 | A translation entry matched |
| tlb_way_i | input | 2 | Way of the matching entry |
| tlb_prot_i | input | 2 | Protection field of the matching entry |
| tlb_dirty_i | input | 1 | Dirty bit of the matching entry |
| exc_o | output | 1 | Exception strobe; also requests saving PC and status word |
| exc_code_o | output | 12 | Event code |
| vec_off_o | output | 12 | Vector offset from the base register |
| sr_o | output | 32 | Status word to load on exception |
| fault_addr_o | output | 32 | Captured fault address |
| fault_vpn_o | output | 22 | Captured virtual page number |
| fault_asid_o | output | 8 | Captured address space identifier |
| fault_way_o | output | 2 | Captured way of the faulting entry |

## Verification
The bench covers every combination of protection value, mode and direction. A design with a wrong decode would let a user access through on values 0 or 1, or would fault a privileged write on value 1. It also presents accesses that fail two checks at once, for example misaligned and protection-denied, or protection-denied and clean-page write. A design with the wrong priority would report the lower-priority code. Byte accesses at odd addresses, words at 4n+2 and privileged accesses to the upper half check that nothing is over-flagged. Address errors that follow a TLB fault check that the page-number, ASID and way captures are not overwritten with the wrong context.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam int EV_W = 12;
  localparam logic [EV_W-1:0] EV_NONE     = 12'h000;
  localparam logic [EV_W-1:0] EV_CLEAN_WR = 12'h080;
  localparam logic [EV_W-1:0] EV_PROT_RD  = 12'h0A0;
  localparam logic [EV_W-1:0] EV_PROT_WR  = 12'h0C0;
  localparam logic [EV_W-1:0] EV_ALGN_RD  = 12'h0E0;
  localparam logic [EV_W-1:0] EV_ALGN_WR  = 12'h100;
  localparam logic [EV_W-1:0] VEC_GENERAL = 12'h100;

  // status word bits forced on exception entry
  localparam int SR_BLOCK_BIT = 28;
  localparam int SR_BANK_BIT  = 29;
  localparam int SR_MODE_BIT  = 30;

  typedef enum logic [1:0] {
    FLT_NONE,
    FLT_ALIGN,
    FLT_PROT,
    FLT_CLEAN
  } fault_kind_e;
endpackage

// File: rtl/mmu_align_check.sv
module mmu_align_check
  import mmu_chk_pkg::*;
(
  input  logic [1:0] addr_lo_i,
  input  logic       addr_msb_i,
  input  acc_kind_e  kind_i,
  input  acc_size_e  size_i,
  input  logic       priv_i,
  output logic       misalign_o,
  output logic       area_viol_o
);
  logic fetch_odd, word_odd, long_off;

  always_comb begin
    fetch_odd = (kind_i == ACC_FETCH) && addr_lo_i[0];
    word_odd  = (size_i == SZ_WORD) && addr_lo_i[0];
    long_off  = ((size_i == SZ_LONG) || (size_i == SZ_WIDE)) && (addr_lo_i != 2'b00);
    misalign_o  = fetch_odd || word_odd || long_off;
    area_viol_o = !priv_i && addr_msb_i;
  end
endmodule

// File: rtl/mmu_prot_check.sv
module mmu_prot_check
  import mmu_chk_pkg::*;
(
  input  logic       hit_i,
  input  logic [1:0] prot_i,
  input  logic       dirty_i,
  input  logic       priv_i,
  input  logic       is_write_i,
  output logic       prot_viol_o,
  output logic       clean_wr_o
);
  logic can_read, can_write;

  // prot[1]: user may access; prot[0]: writes allowed
  always_comb begin
    can_read  = priv_i || prot_i[1];
    can_write = can_read && prot_i[0];
    prot_viol_o = hit_i && (is_write_i ? !can_write : !can_read);
    clean_wr_o  = hit_i && is_write_i && can_write && !dirty_i;
  end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int ASID_W     = 8,
  parameter int WAY_W      = 2,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              tlb_ctx_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic [VA_W-1:0]   fault_addr_o,
  output logic [VPN_W-1:0]  fault_vpn_o,
  output logic [ASID_W-1:0] fault_asid_o,
  output logic [WAY_W-1:0]  fault_way_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_addr_o <= '0;
    end else if (take_i) begin
      fault_addr_o <= vaddr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_vpn_o  <= '0;
      fault_asid_o <= '0;
      fault_way_o  <= '0;
    end else if (take_i && tlb_ctx_i) begin
      fault_vpn_o  <= vaddr_i[VA_W-1:PAGE_SHIFT];
      fault_asid_o <= asid_i;
      fault_way_o  <= way_i;
    end
  end
endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
  import mmu_chk_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int ASID_W     = 8,
  parameter int WAY_W      = 2,
  parameter int SR_W       = 32,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [1:0]        kind_i,
  input  logic [1:0]        size_i,
  input  logic              priv_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic              tlb_hit_i,
  input  logic [WAY_W-1:0]  tlb_way_i,
  input  logic [1:0]        tlb_prot_i,
  input  logic              tlb_dirty_i,
  output logic              exc_o,
  output logic [EV_W-1:0]   exc_code_o,
  output logic [EV_W-1:0]   vec_off_o,
  output logic [SR_W-1:0]   sr_o,
  output logic [VA_W-1:0]   fault_addr_o,
  output logic [VPN_W-1:0]  fault_vpn_o,
  output logic [ASID_W-1:0] fault_asid_o,
  output logic [WAY_W-1:0]  fault_way_o
);
  acc_kind_e   kind;
  acc_size_e   size;
  logic        is_write;
  logic        misalign, area_viol, prot_viol, clean_wr;
  fault_kind_e fault;

  assign kind     = acc_kind_e'(kind_i);
  assign size     = acc_size_e'(size_i);
  assign is_write = (kind == ACC_WRITE);

  mmu_align_check u_align (
    .addr_lo_i  (vaddr_i[1:0]),
    .addr_msb_i (vaddr_i[VA_W-1]),
    .kind_i     (kind),
    .size_i     (size),
    .priv_i     (priv_i),
    .misalign_o (misalign),
    .area_viol_o(area_viol)
  );

  mmu_prot_check u_prot (
    .hit_i      (tlb_hit_i),
    .prot_i     (tlb_prot_i),
    .dirty_i    (tlb_dirty_i),
    .priv_i     (priv_i),
    .is_write_i (is_write),
    .prot_viol_o(prot_viol),
    .clean_wr_o (clean_wr)
  );

  // one event per access, highest priority wins
  always_comb begin
    fault = FLT_NONE;
    if (valid_i) begin
      if (misalign || area_viol) fault = FLT_ALIGN;
      else if (prot_viol)        fault = FLT_PROT;
      else if (clean_wr)         fault = FLT_CLEAN;
    end
  end

  always_comb begin
    exc_o      = (fault != FLT_NONE);
    exc_code_o = EV_NONE;
    unique case (fault)
      FLT_ALIGN: exc_code_o = is_write ? EV_ALGN_WR : EV_ALGN_RD;
      FLT_PROT:  exc_code_o = is_write ? EV_PROT_WR : EV_PROT_RD;
      FLT_CLEAN: exc_code_o = EV_CLEAN_WR;
      default:   exc_code_o = EV_NONE;
    endcase
    vec_off_o = exc_o ? VEC_GENERAL : '0;
  end

  always_comb begin
    sr_o = sr_i;
    if (exc_o) begin
      sr_o[SR_BLOCK_BIT] = 1'b1;
      sr_o[SR_BANK_BIT]  = 1'b1;
      sr_o[SR_MODE_BIT]  = 1'b1;
    end
  end

  mmu_fault_capture #(
    .VA_W      (VA_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .ASID_W    (ASID_W),
    .WAY_W     (WAY_W)
  ) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (exc_o),
    .tlb_ctx_i   (fault == FLT_PROT || fault == FLT_CLEAN),
    .vaddr_i     (vaddr_i),
    .asid_i      (asid_i),
    .way_i       (tlb_way_i),
    .fault_addr_o(fault_addr_o),
    .fault_vpn_o (fault_vpn_o),
    .fault_asid_o(fault_asid_o),
    .fault_way_o (fault_way_o)
  );
endmodule

// File: rtl/mmu_access_check_sva.sv
module mmu_access_check_sva #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int ASID_W     = 8,
  parameter int WAY_W      = 2,
  parameter int SR_W       = 32,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [VA_W-1:0]   vaddr_i,
  input logic [1:0]        kind_i,
  input logic [1:0]        size_i,
  input logic              priv_i,
  input logic [ASID_W-1:0] asid_i,
  input logic [SR_W-1:0]   sr_i,
  input logic              tlb_hit_i,
  input logic [WAY_W-1:0]  tlb_way_i,
  input logic              exc_o,
  input logic [11:0]       exc_code_o,
  input logic [11:0]       vec_off_o,
  input logic [SR_W-1:0]   sr_o,
  input logic [VA_W-1:0]   fault_addr_o,
  input logic [VPN_W-1:0]  fault_vpn_o,
  input logic [ASID_W-1:0] fault_asid_o,
  input logic [WAY_W-1:0]  fault_way_o
);
  logic tlb_code, algn_code;
  assign tlb_code  = (exc_code_o == 12'h080) || (exc_code_o == 12'h0A0) || (exc_code_o == 12'h0C0);
  assign algn_code = (exc_code_o == 12'h0E0) || (exc_code_o == 12'h100);

  AST_USER_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !priv_i && vaddr_i[VA_W-1] |-> exc_o && algn_code); // R2
  AST_BYTE_PRIV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == 2'd0 && kind_i != 2'd0 && priv_i && !tlb_hit_i |-> !exc_o); // R1
  AST_NO_HIT_NO_TLB_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tlb_hit_i |-> !tlb_code); // R5
  AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> tlb_code || algn_code); // R7
  AST_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> vec_off_o == 12'h100); // R8
  AST_QUIET_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |-> exc_code_o == 12'h000 && vec_off_o == 12'h000 && sr_o == sr_i); // R8
  AST_SR_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> sr_o[30:28] == 3'b111 && sr_o[27:0] == sr_i[27:0] && sr_o[31] == sr_i[31]); // R9
  AST_CAP_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> fault_addr_o == $past(vaddr_i)); // R10
  AST_CAP_CTX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o && tlb_code |=> fault_vpn_o == $past(vaddr_i[VA_W-1:PAGE_SHIFT])
      && fault_asid_o == $past(asid_i) && fault_way_o == $past(tlb_way_i)); // R10
  AST_ALGN_KEEPS_CTX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o && algn_code |=> $stable(fault_vpn_o) && $stable(fault_asid_o) && $stable(fault_way_o)); // R10
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |=> $stable(fault_addr_o) && $stable(fault_vpn_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !exc_o); // R11
endmodule

bind mmu_access_check mmu_access_check_sva #(
  .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .ASID_W(ASID_W), .WAY_W(WAY_W), .SR_W(SR_W)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .vaddr_i(vaddr_i),
  .kind_i(kind_i), .size_i(size_i), .priv_i(priv_i), .asid_i(asid_i), .sr_i(sr_i),
  .tlb_hit_i(tlb_hit_i), .tlb_way_i(tlb_way_i), .exc_o(exc_o), .exc_code_o(exc_code_o),
  .vec_off_o(vec_off_o), .sr_o(sr_o), .fault_addr_o(fault_addr_o),
  .fault_vpn_o(fault_vpn_o), .fault_asid_o(fault_asid_o), .fault_way_o(fault_way_o)
);

// File: tb/test_mmu_access_check.sv
module test_mmu_access_check;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  kind = '0, size = '0, way = '0, prot = '0;
  logic        priv = 1'b0, hit = 1'b0, dirty = 1'b0;
  logic [7:0]  asid = '0;
  logic [31:0] sr = '0;
  logic        exc;
  logic [11:0] code, vec;
  logic [31:0] sr_out, f_addr;
  logic [21:0] f_vpn;
  logic [7:0]  f_asid;
  logic [1:0]  f_way;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_addr = '0;
  logic [21:0] m_vpn = '0;
  logic [7:0]  m_asid = '0;
  logic [1:0]  m_way = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_access_check i_mmu_access_check (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .vaddr_i(vaddr), .kind_i(kind),
    .size_i(size), .priv_i(priv), .asid_i(asid), .sr_i(sr), .tlb_hit_i(hit),
    .tlb_way_i(way), .tlb_prot_i(prot), .tlb_dirty_i(dirty), .exc_o(exc),
    .exc_code_o(code), .vec_off_o(vec), .sr_o(sr_out), .fault_addr_o(f_addr),
    .fault_vpn_o(f_vpn), .fault_asid_o(f_asid), .fault_way_o(f_way)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit may(input logic [1:0] p, input logic pv, input logic wr);
    case (p)
      2'd0: return pv && !wr;
      2'd1: return pv;
      2'd2: return !wr;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [11:0] model_code(input logic v, input logic [31:0] a, input logic [1:0] k,
      input logic [1:0] s, input logic pv, input logic h, input logic [1:0] p, input logic d);
    logic wr, mis;
    wr  = (k == 2'd2);
    mis = (k == 2'd0 && a[0]) || (s == 2'd1 && a[0]) || (s >= 2'd2 && a[1:0] != 2'b00);
    if (!v) return 12'h000;
    if (mis || (!pv && a[31])) return wr ? 12'h100 : 12'h0E0;
    if (h && !may(p, pv, wr)) return wr ? 12'h0C0 : 12'h0A0;
    if (h && wr && !d) return 12'h080;
    return 12'h000;
  endfunction

  task automatic apply(input logic v, input logic [31:0] a, input logic [1:0] k, input logic [1:0] s,
      input logic pv, input logic h, input logic [1:0] p, input logic d, input string tag);
    logic [11:0] ec;
    logic [31:0] esr;
    @(negedge clk);
    valid = v; vaddr = a; kind = k; size = s; priv = pv; hit = h; prot = p; dirty = d;
    asid = 8'($urandom); way = 2'($urandom); sr = $urandom;
    #1;
    ec  = model_code(v, a, k, s, pv, h, p, d);
    esr = sr;
    if (ec != 0) esr[30:28] = 3'b111;
    chk(exc == (ec != 0) && code == ec, tag, {20'd0, code}, {20'd0, ec});
    chk(vec == ((ec != 0) ? 12'h100 : 12'h000), "R8", {20'd0, vec}, (ec != 0) ? 32'h100 : 32'h0);
    chk(sr_out == esr, "R9", sr_out, esr);
    if (ec != 0) begin
      m_addr = a;
      if (ec == 12'h080 || ec == 12'h0A0 || ec == 12'h0C0) begin
        m_vpn = a[31:10]; m_asid = asid; m_way = way;
      end
    end
    @(posedge clk); #1;
    chk(f_addr == m_addr, "R10 addr", f_addr, m_addr);
    chk(f_vpn == m_vpn && f_asid == m_asid && f_way == m_way, "R10 ctx",
        {f_vpn, f_way, f_asid}, {m_vpn, m_way, m_asid});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(f_addr == 0 && f_vpn == 0 && f_asid == 0 && f_way == 0, "R11 reset",
        f_addr | {10'd0, f_vpn}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R11: idle access ignored even when it would fault
    apply(0, 32'hF000_0003, 2'd2, 2'd2, 0, 1, 2'd0, 0, "R11 idle");
    // R1: alignment corners
    apply(1, 32'h0000_1003, 2'd1, 2'd0, 1, 0, 2'd0, 1, "R1 byte odd");
    apply(1, 32'h0000_1001, 2'd0, 2'd0, 1, 0, 2'd0, 1, "R1 fetch odd");
    apply(1, 32'h0000_1002, 2'd1, 2'd1, 1, 0, 2'd0, 1, "R1 word 4n+2");
    apply(1, 32'h0000_1003, 2'd1, 2'd1, 1, 0, 2'd0, 1, "R1 word 4n+3");
    apply(1, 32'h0000_1002, 2'd1, 2'd2, 1, 0, 2'd0, 1, "R1 long 4n+2");
    apply(1, 32'h0000_1004, 2'd1, 2'd2, 1, 0, 2'd0, 1, "R1 long aligned");
    // R3: write alignment code
    apply(1, 32'h0000_2001, 2'd2, 2'd1, 1, 0, 2'd0, 1, "R3 write misaligned");
    // R2: upper area
    apply(1, 32'h8000_0000, 2'd1, 2'd2, 0, 0, 2'd0, 1, "R2 user upper");
    apply(1, 32'h8000_0000, 2'd1, 2'd2, 1, 0, 2'd0, 1, "R2 priv upper");
    // R4 R5: full protection table
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 2; m++)
        for (int k = 0; k < 3; k++)
          apply(1, 32'h0012_3400, 2'(k), 2'd2, 1'(m), 1, 2'(p), 1, "R4 R5 prot table");
    apply(1, 32'h0012_3400, 2'd2, 2'd2, 0, 0, 2'd0, 1, "R5 miss no prot");
    // R6 clean write
    apply(1, 32'h0045_6000, 2'd2, 2'd2, 0, 1, 2'd3, 0, "R6 clean write");
    apply(1, 32'h0045_6000, 2'd1, 2'd2, 0, 1, 2'd3, 0, "R6 read clean page");
    // R7 priority
    apply(1, 32'h0045_6000, 2'd2, 2'd2, 1, 1, 2'd0, 0, "R7 prot over clean");
    apply(1, 32'h0045_6002, 2'd2, 2'd2, 0, 1, 2'd0, 0, "R7 align over prot");
    apply(1, 32'h8045_6000, 2'd1, 2'd0, 0, 1, 2'd0, 1, "R7 area over prot");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom_range(1, 0) == 1) a[31] = 1'b0;
      if ($urandom_range(1, 0) == 1) a[1:0] = 2'b00;
      apply($urandom_range(7, 0) != 0, a, 2'($urandom_range(2, 0)), 2'($urandom),
            1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), "R7 random");
    end

    // R11 reset clears captures after faults
    @(negedge clk); valid = 1'b0; rst_n = 1'b0; #1;
    chk(f_addr == 0 && f_vpn == 0 && f_asid == 0 && f_way == 0, "R11 re-reset",
        f_addr | {10'd0, f_vpn}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule